// File: doc/BRIEF.md
# Calibration Pattern Read Responder

This block sits on the memory side of a training link. While the training-pattern mode is switched on, it answers each READ command with a fixed burst of alternating bits. The host controller uses these beats to align its capture window before the real array is read. Array contents play no part here. Each accepted READ produces a burst of four or eight beats on a byte-wide data output. The beats come one per clock and a valid flag is high while they are on the output. A beat index shows the burst-order position of each beat.

Two things decide the burst shape: a two-bit burst-mode setting and two bits of the command's column address. In on-the-fly mode, address bit 12 chooses between the full eight-beat burst and the four-beat chop. For a chopped burst, address bit 2 chooses the lower or upper half of the burst order. Every other address bit and the bank bits are ignored. A READ sent while one of the reserved location codes is selected is refused and flagged. A READ that arrives while beats are still pending is also refused and flagged, and the running burst goes on unchanged.

Top module: `cal_pat_responder`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `dq_valid`, `dq_out`, `beat_idx`, `err_reserved` and `err_busy` are all 0.
- R2: While `pat_mode_en` is 0, a READ produces no beats and no error flag.
- R3: With `pat_mode_en` at 1 and `pat_sel` at 01, 10 or 11, a READ raises `err_reserved` for one cycle, in the cycle after the command. It produces no beats, and a burst already running continues unchanged. Only `pat_sel` = 00 selects the pattern.
- R4: An accepted READ puts its first beat out in the cycle after the command and then one beat per clock. `dq_valid` is high exactly during those beats.
- R5: During a beat, every bit of `dq_out` equals bit 0 of `beat_idx`: 0 on the first beat, 1 on the second, and alternating after that. When no beat is present, `dq_out` is 0.
- R6: `bl_mode` encoding: when bit 0 is 1 the burst is on-the-fly, and address bit 12 = 1 gives eight beats while 0 gives four. When bit 0 is 0, bit 1 = 0 fixes eight beats and bit 1 = 1 fixes four beats, and address bit 12 is ignored.
- R7: An eight-beat burst shows `beat_idx` 0,1,...,7 whatever the values of address bits 2:0.
- R8: A four-beat burst shows `beat_idx` 0,1,2,3 when address bit 2 is 0 and 4,5,6,7 when it is 1. Either way the data reads 0,1,0,1.
- R9: Address bits 13, 11, 10, 9:3 and 1:0 and all `rd_bank` bits have no effect on a burst.
- R10: A READ arriving while more beats follow the one on the output is refused. `err_busy` goes high for one cycle, in the next cycle, and the burst continues. A READ arriving on the final beat is accepted, and its burst follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_mode_en | input | 1 | Training-pattern mode on |
| pat_sel | input | 2 | Location select, 00 = calibration pattern, others reserved |
| bl_mode | input | 2 | Burst-mode setting (see R6) |
| rd_cmd | input | 1 | READ command strobe, one cycle |
| rd_addr | input | ADDR_W (14) | Column address of the READ |
| rd_bank | input | BANK_W (3) | Bank address of the READ, ignored |
| dq_out | output | DQ_W (8) | Beat data |
| dq_valid | output | 1 | Beat present on `dq_out` |
| beat_idx | output | 3 | Burst-order position of the current beat |
| err_reserved | output | 1 | READ refused for a reserved location code |
| err_busy | output | 1 | READ refused because a burst is in progress |

## Verification
Two events can land on the same clock edge: the last beat of a burst and the arrival of the next READ. The bench places a READ two beats into an eight-beat burst and expects a busy flag while the burst keeps counting. It then places a READ exactly on the final beat and expects a four-beat upper-half burst to follow with no idle cycle and no flag. A reserved-code READ placed in mid-burst checks the second overlap, an error report alongside running beats, which must leave the beat sequence intact.

// File: rtl/cal_pat_pkg.sv
package cal_pat_pkg;

    localparam int BEATS_FULL = 8;
    localparam int BEATS_CHOP = 4;
    localparam int ORD_W      = 3;
    localparam int CNT_W      = $clog2(BEATS_FULL + 1);

    // Address bit positions that carry meaning for a pattern READ
    localparam int ADDR_CHOP_BIT = 12;
    localparam int ADDR_HALF_BIT = 2;

    localparam logic [1:0] SEL_PATTERN = 2'b00;

    typedef enum logic {
        BURST_FULL = 1'b0,
        BURST_CHOP = 1'b1
    } burst_e;

    typedef struct packed {
        burst_e           kind;
        logic [ORD_W-1:0] start;
    } burst_plan_t;

    typedef enum logic [1:0] {
        CMD_IGNORE   = 2'd0,
        CMD_ACCEPT   = 2'd1,
        CMD_RESERVED = 2'd2,
        CMD_BUSY     = 2'd3
    } cmd_verdict_e;

    // bl_mode[0]=1: on-the-fly via chop bit; else bl_mode[1] fixes chop
    function automatic burst_plan_t plan_burst(input logic [1:0] bl_mode,
                                               input logic       chop_bit,
                                               input logic       half_bit);
        burst_plan_t p;
        logic        chop;
        chop    = bl_mode[0] ? ~chop_bit : bl_mode[1];
        p.kind  = chop ? BURST_CHOP : BURST_FULL;
        p.start = chop ? {half_bit, 2'b00} : '0;
        return p;
    endfunction

    function automatic logic [CNT_W-1:0] burst_beats(input burst_e kind);
        return (kind == BURST_CHOP) ? CNT_W'(BEATS_CHOP) : CNT_W'(BEATS_FULL);
    endfunction

    // Pattern is 0,1,0,1... following the burst-order position
    function automatic logic pattern_bit(input logic [ORD_W-1:0] ord);
        return ord[0];
    endfunction

endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
    import cal_pat_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              rd_cmd,
    input  logic              pat_mode_en,
    input  logic [1:0]        pat_sel,
    input  logic [1:0]        bl_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    output cmd_verdict_e      verdict,
    output burst_plan_t       plan
);

    always_comb begin
        plan = plan_burst(bl_mode, rd_addr[ADDR_CHOP_BIT], rd_addr[ADDR_HALF_BIT]);
        if (!rd_cmd || !pat_mode_en) begin
            verdict = CMD_IGNORE;
        end else if (pat_sel != SEL_PATTERN) begin
            verdict = CMD_RESERVED;
        end else if (busy) begin
            verdict = CMD_BUSY;
        end else begin
            verdict = CMD_ACCEPT;
        end
    end

endmodule

// File: rtl/cal_beat_gen.sv
module cal_beat_gen
    import cal_pat_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  burst_plan_t      plan,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_valid,
    output logic [ORD_W-1:0] beat_idx,
    output logic             busy
);

    logic [CNT_W-1:0] left_q;
    logic [ORD_W-1:0] next_ord;
    logic             lane_bit_d;
    logic             load_beat;

    assign next_ord  = start ? plan.start : beat_idx + ORD_W'(1);
    assign load_beat = start || (left_q > CNT_W'(1));
    assign lane_bit_d = load_beat && pattern_bit(next_ord);
    assign busy      = left_q > CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= '0;
            beat_idx <= '0;
            dq_valid <= 1'b0;
        end else if (start) begin
            left_q   <= burst_beats(plan.kind);
            beat_idx <= plan.start;
            dq_valid <= 1'b1;
        end else if (left_q > CNT_W'(1)) begin
            left_q   <= left_q - CNT_W'(1);
            beat_idx <= next_ord;
        end else begin
            left_q   <= '0;
            beat_idx <= '0;
            dq_valid <= 1'b0;
        end
    end

    // One flop per data lane, each carrying the pattern bit
    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                dq_out[g] <= 1'b0;
            end else begin
                dq_out[g] <= lane_bit_d;
            end
        end
    end

    assert_pattern_R5: assert property (@(posedge clk) disable iff (rst)
        dq_valid |-> (dq_out == {DQ_W{beat_idx[0]}}));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !dq_valid |-> (dq_out == '0));

    assert_beat_step_R4: assert property (@(posedge clk) disable iff (rst)
        (dq_valid && busy && !start) |=> (dq_valid && beat_idx == $past(beat_idx) + ORD_W'(1)));

endmodule

// File: rtl/cal_pat_responder.sv
module cal_pat_responder
    import cal_pat_pkg::*;
#(
    parameter int DQ_W   = 8,
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pat_mode_en,
    input  logic [1:0]        pat_sel,
    input  logic [1:0]        bl_mode,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_valid,
    output logic [ORD_W-1:0]  beat_idx,
    output logic              err_reserved,
    output logic              err_busy
);

    cmd_verdict_e verdict;
    burst_plan_t  plan;
    logic         busy;

    cal_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .rd_cmd      (rd_cmd),
        .pat_mode_en (pat_mode_en),
        .pat_sel     (pat_sel),
        .bl_mode     (bl_mode),
        .rd_addr     (rd_addr),
        .busy        (busy),
        .verdict     (verdict),
        .plan        (plan)
    );

    cal_beat_gen #(.DQ_W(DQ_W)) u_beats (
        .clk      (clk),
        .rst      (rst),
        .start    (verdict == CMD_ACCEPT),
        .plan     (plan),
        .dq_out   (dq_out),
        .dq_valid (dq_valid),
        .beat_idx (beat_idx),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_reserved <= 1'b0;
            err_busy     <= 1'b0;
        end else begin
            err_reserved <= (verdict == CMD_RESERVED);
            err_busy     <= (verdict == CMD_BUSY);
        end
    end

    assert_cmd_bus_known_R9: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |-> !$isunknown({pat_mode_en, pat_sel, bl_mode, rd_addr, rd_bank}));

    assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (!pat_mode_en && !dq_valid) |=> (!dq_valid && !err_reserved && !err_busy));

    assert_reserved_no_beats_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && pat_mode_en && pat_sel != SEL_PATTERN && !dq_valid) |=> !dq_valid);

    assert_err_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_reserved, err_busy}));

    assert_busy_keeps_burst_R10: assert property (@(posedge clk) disable iff (rst)
        err_busy |-> dq_valid);

endmodule

// File: tb/cal_pat_responder_tb.sv
`timescale 1ns/1ps
module cal_pat_responder_tb;

    localparam int DQ_W   = 8;
    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pat_mode_en = 1'b0;
    logic [1:0]        pat_sel = 2'b00;
    logic [1:0]        bl_mode = 2'b00;
    logic              rd_cmd = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [BANK_W-1:0] rd_bank = '0;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_valid;
    logic [2:0]        beat_idx;
    logic              err_reserved;
    logic              err_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cal_pat_responder #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dut (
        .clk(clk), .rst(rst), .pat_mode_en(pat_mode_en), .pat_sel(pat_sel),
        .bl_mode(bl_mode), .rd_cmd(rd_cmd), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .dq_out(dq_out), .dq_valid(dq_valid), .beat_idx(beat_idx),
        .err_reserved(err_reserved), .err_busy(err_busy)
    );

    // Vector: [11:10] bl_mode, [9] A12, [8] A2, [7] noise on ignored bits,
    //         [6:3] expected beats, [2:0] expected first beat index
    localparam logic [11:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b1, 1'b1, 4'd8, 3'd0},
        {2'b10, 1'b1, 1'b0, 1'b0, 4'd4, 3'd0},
        {2'b10, 1'b1, 1'b1, 1'b1, 4'd4, 3'd4},
        {2'b01, 1'b1, 1'b1, 1'b0, 4'd8, 3'd0},
        {2'b01, 1'b0, 1'b0, 1'b1, 4'd4, 3'd0},
        {2'b01, 1'b0, 1'b1, 1'b0, 4'd4, 3'd4},
        {2'b11, 1'b1, 1'b0, 1'b1, 4'd8, 3'd0},
        {2'b11, 1'b0, 1'b1, 1'b1, 4'd4, 3'd4}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input logic a12, input logic a2, input logic n);
        return {n, a12, n, n, {7{n}}, a2, n, n};
    endfunction

    function automatic logic [DQ_W-1:0] exp_data(input int i);
        return (i % 2 == 1) ? {DQ_W{1'b1}} : '0;
    endfunction

    // Called at a negedge with the block idle; returns at the negedge after the burst
    task automatic run_burst(input logic [1:0] bl, input logic [ADDR_W-1:0] a,
                             input logic [BANK_W-1:0] bk, input int n_beats,
                             input int first, input string req);
        bl_mode = bl; rd_addr = a; rd_bank = bk; rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int i = 0; i < n_beats; i++) begin
            check(dq_valid == 1'b1, {req, " valid"}, int'(dq_valid), 1);
            check(beat_idx == 3'(first + i), {req, " index"}, int'(beat_idx), (first + i) % 8);
            check(dq_out == exp_data(i), {req, " R5 data"}, int'(dq_out), int'(exp_data(i)));
            @(negedge clk);
        end
        check(dq_valid == 1'b0, {req, " R4 end"}, int'(dq_valid), 0);
        check(dq_out == '0, {req, " R5 idle data"}, int'(dq_out), 0);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(dq_valid == 0 && err_reserved == 0 && err_busy == 0, "R1 flags", int'(dq_valid), 0);
        check(dq_out == '0 && beat_idx == 3'd0, "R1 data", int'(dq_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: mode off ignores READ
        pat_mode_en = 1'b0;
        bl_mode = 2'b00; rd_addr = '0; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        check(dq_valid == 0, "R2 no beat", int'(dq_valid), 0);
        check(err_reserved == 0 && err_busy == 0, "R2 no error", int'(err_reserved), 0);
        @(negedge clk);
        check(dq_valid == 0, "R2 still idle", int'(dq_valid), 0);

        pat_mode_en = 1'b1;

        // R6 R7 R8 R9: vector table
        for (int v = 0; v < 8; v++) begin
            logic [11:0] e;
            e = VEC[v];
            run_burst(e[11:10], mk_addr(e[9], e[8], e[7]), {BANK_W{e[7]}},
                      int'(e[6:3]), int'(e[2:0]), $sformatf("R6 R7 R8 R9 vec%0d", v));
        end

        // R3: reserved codes while idle
        for (int s = 1; s < 4; s++) begin
            pat_sel = 2'(s); rd_cmd = 1'b1;
            @(negedge clk); rd_cmd = 1'b0;
            check(err_reserved == 1, "R3 flag", int'(err_reserved), 1);
            check(dq_valid == 0, "R3 no beat", int'(dq_valid), 0);
            @(negedge clk);
            check(err_reserved == 0 && dq_valid == 0, "R3 one pulse", int'(err_reserved), 0);
        end
        pat_sel = 2'b00;

        // R3: reserved READ during a burst leaves the burst intact
        bl_mode = 2'b00; rd_addr = '0; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        @(negedge clk);
        pat_sel = 2'b10; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0; pat_sel = 2'b00;
        check(err_reserved == 1, "R3 flag mid-burst", int'(err_reserved), 1);
        check(dq_valid == 1 && beat_idx == 3'd2, "R3 burst continues", int'(beat_idx), 2);
        repeat (5) @(negedge clk);
        check(dq_valid == 1 && beat_idx == 3'd7, "R3 burst last beat", int'(beat_idx), 7);
        @(negedge clk);
        check(dq_valid == 0, "R3 burst ends", int'(dq_valid), 0);

        // R10: busy refusal, then seamless accept on final beat
        bl_mode = 2'b00; rd_addr = '0; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        repeat (2) @(negedge clk);
        bl_mode = 2'b10; rd_addr = mk_addr(1'b0, 1'b1, 1'b0); rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        check(err_busy == 1, "R10 busy flag", int'(err_busy), 1);
        check(dq_valid == 1 && beat_idx == 3'd3, "R10 burst continues", int'(beat_idx), 3);
        repeat (4) @(negedge clk);
        check(beat_idx == 3'd7 && err_busy == 0, "R10 final beat", int'(beat_idx), 7);
        rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        check(err_busy == 0, "R10 no flag on final beat", int'(err_busy), 0);
        for (int i = 0; i < 4; i++) begin
            check(dq_valid == 1 && beat_idx == 3'(4 + i), "R10 seamless burst", int'(beat_idx), 4 + i);
            check(dq_out == exp_data(i), "R10 seamless data", int'(dq_out), int'(exp_data(i)));
            @(negedge clk);
        end
        check(dq_valid == 0, "R4 after seamless", int'(dq_valid), 0);

        // R1: reset in mid-burst
        bl_mode = 2'b00; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dq_valid == 0 && dq_out == '0 && beat_idx == 3'd0, "R1 mid-burst reset", int'(dq_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule